// File: doc/BRIEF.md
# Eight-Channel Countdown Timer Bank

The block holds eight independent down-counters behind a single APB slave port. Each channel has the following registers:

- a load value;
- a read-only view of its running count;
- a control word with enable, reload/free-run select, interrupt mask and a stored trigger-enable bit;
- a read-to-clear acknowledge register;
- a masked interrupt status bit.

Each channel drives its own interrupt line, which is the raw expiry flag gated by the mask bit.

Three shared registers sit above the channel windows. Two report the masked and the raw interrupt state of every channel as a bit vector. The third clears every channel's flag in a single read.

Software writes a load value, then sets the enable bit. The counter then steps down once per clock. When the count passes zero, the channel raises its flag and either reloads or wraps to all ones. Software acknowledges the interrupt by reading an acknowledge register.

Top module: `apb_timer_bank`

## Requirements
- R1: After reset every load, control and count register reads zero, every raw flag is clear and `irq_o` is zero.
- R2: Channel n occupies byte offsets n*0x14 to n*0x14+0x13, with these registers at the given offsets:
  - 0x00: load value, read/write.
  - 0x04: running count, read-only.
  - 0x08: control, read/write. Bit 0 is enable, bit 1 is reload mode (1 reload, 0 free-run), bit 2 is mask, bit 4 is trigger enable. All other control bits read 0.
  - 0x0C: acknowledge.
  - 0x10: status.
- R3: A control write that changes enable from 0 to 1 loads the count from the load value (reload mode) or from all ones (free-run mode). After that, the count drops by one on every clock.
- R4: In reload mode, when the count is zero on a clock edge, the raw flag is set and the count becomes the load value.
- R5: In free-run mode, when the count is zero on a clock edge, the raw flag is set and the count becomes all ones. Changing the mode bit while enabled does not restart the count.
- R6: A control write with enable 0 stops the channel and makes its count read zero. A raw flag that is already set stays set.
- R7: Reading the acknowledge register returns the raw flag in bit 0 and clears the flag. An expiry on the same clock edge wins over the clear.
- R8: A channel's interrupt output and the bit 0 of its status register are both the raw flag AND NOT mask. The mask has no effect on the raw flag.
- R9: Bank offset 0xA0 reads the masked interrupt vector and 0xA8 reads the raw flag vector, with bit n belonging to channel n.
- R10: Reading bank offset 0xA4 returns the masked vector and clears the raw flags of all channels.
- R11: Every access completes in its access phase (`pready_o` high). Writes to read-only or unmapped offsets change nothing, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write (1) or read (0) |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | DATA_W | APB write data |
| prdata_o | output | DATA_W | APB read data, valid in the access phase |
| pready_o | output | 1 | APB ready, always high |
| irq_o | output | NUM_CH | Per-channel interrupt |

## Verification
The properties assume a well-formed APB master: `penable_i` is raised only in the cycle after a setup phase, and address, direction and data are held through the access phase. The stimulus meets this because every access goes through one task that drives a setup cycle, an access cycle and an idle cycle. The expiry and acknowledge properties also assume that acknowledge reads never coincide with an expiry unless the same-edge rule is intended. To keep within this, the bench disables a channel before acknowledging it whenever it checks that the flag clears. The mode switch to free-run is issued several cycles before the count reaches zero, so the wrap point is known in advance.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int unsigned CH_SPAN   = 20;
  localparam int unsigned OFF_LOAD  = 0;
  localparam int unsigned OFF_CUR   = 4;
  localparam int unsigned OFF_CTRL  = 8;
  localparam int unsigned OFF_ACK   = 12;
  localparam int unsigned OFF_STAT  = 16;
  localparam int unsigned BANK_MSK  = 32'hA0;
  localparam int unsigned BANK_CLR  = 32'hA4;
  localparam int unsigned BANK_RAW  = 32'hA8;

  typedef struct packed {
    logic trig;
    logic mask;
    logic reload;
    logic en;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [4:0] w);
    ctrl_t c;
    c.en     = w[0];
    c.reload = w[1];
    c.mask   = w[2];
    c.trig   = w[4];
    return c;
  endfunction

  function automatic logic [4:0] ctrl_pack(input ctrl_t c);
    return {c.trig, 1'b0, c.mask, c.reload, c.en};
  endfunction
endpackage

// File: rtl/timer_addr_decode.sv
module timer_addr_decode
  import timer_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned OFF_W  = 5
) (
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  output logic              wr_o,
  output logic              rd_o,
  output logic [NUM_CH-1:0] ch_hit_o,
  output logic [OFF_W-1:0]  ch_off_o,
  output logic              bank_msk_o,
  output logic              bank_clr_o,
  output logic              bank_raw_o
);
  logic [31:0] addr_ext;
  logic        access;

  assign addr_ext = 32'(paddr_i);
  assign access   = psel_i & penable_i;
  assign wr_o     = access & pwrite_i;
  assign rd_o     = access & ~pwrite_i;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hit
    localparam logic [31:0] BASE = 32'(ch * CH_SPAN);
    assign ch_hit_o[ch] = (addr_ext >= BASE) && (addr_ext < BASE + 32'(CH_SPAN));
  end

  always_comb begin
    ch_off_o = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_hit_o[k]) ch_off_o = OFF_W'(addr_ext - 32'(k * CH_SPAN));
    end
  end

  assign bank_msk_o = (addr_ext == 32'(BANK_MSK));
  assign bank_clr_o = (addr_ext == 32'(BANK_CLR));
  assign bank_raw_o = (addr_ext == 32'(BANK_RAW));
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_bank_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bank_clr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              raw_o
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  load_q, cnt_q, cnt_d;
  logic              raw_q, raw_d;
  logic              we_load, we_ctrl, rd_ack;
  logic              start, stop, run, expire;

  assign we_load = sel_i & wr_i & (off_i == OFF_W'(OFF_LOAD));
  assign we_ctrl = sel_i & wr_i & (off_i == OFF_W'(OFF_CTRL));
  assign rd_ack  = sel_i & rd_i & (off_i == OFF_W'(OFF_ACK));
  assign ctrl_d  = ctrl_unpack(wdata_i[4:0]);

  assign start  = we_ctrl & ctrl_d.en & ~ctrl_q.en;
  assign stop   = we_ctrl & ~ctrl_d.en;
  assign run    = ctrl_q.en & ~stop;
  assign expire = run & (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (stop)                cnt_d = '0;
    else if (start)          cnt_d = ctrl_d.reload ? load_q : '1;
    else if (expire)         cnt_d = ctrl_q.reload ? load_q : '1;
    else if (run)            cnt_d = cnt_q - 1'b1;
  end

  // expiry takes priority over a same-edge clear
  always_comb begin
    raw_d = raw_q;
    if (expire)                   raw_d = 1'b1;
    else if (rd_ack | bank_clr_i) raw_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
      raw_q  <= 1'b0;
    end else begin
      if (we_ctrl) ctrl_q <= ctrl_d;
      if (we_load) load_q <= wdata_i[CNT_W-1:0];
      cnt_q <= cnt_d;
      raw_q <= raw_d;
    end
  end

  assign irq_o = raw_q & ~ctrl_q.mask;
  assign raw_o = raw_q;

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      unique case (off_i)
        OFF_W'(OFF_LOAD): rdata_o = DATA_W'(load_q);
        OFF_W'(OFF_CUR):  rdata_o = DATA_W'(cnt_q);
        OFF_W'(OFF_CTRL): rdata_o = DATA_W'(ctrl_pack(ctrl_q));
        OFF_W'(OFF_ACK):  rdata_o = DATA_W'(raw_q);
        OFF_W'(OFF_STAT): rdata_o = DATA_W'(irq_o);
        default:          rdata_o = '0;
      endcase
    end
  end

  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && !we_ctrl && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && ctrl_q.reload && !we_ctrl && cnt_q == '0) |=> (cnt_q == $past(load_q)) && raw_q);

  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && !ctrl_q.reload && !we_ctrl && cnt_q == '0) |=> (&cnt_q) && raw_q);

  p_stop_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_ctrl && !wdata_i[0]) |=> (cnt_q == '0) && !ctrl_q.en);

  p_raw_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.en && !rd_ack && !bank_clr_i) |=> raw_q == $past(raw_q));

  p_ack_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_ack || bank_clr_i) && !(ctrl_q.en && !we_ctrl && cnt_q == '0)) |=> !raw_q);
endmodule

// File: rtl/timer_rdata_mux.sv
module timer_rdata_mux #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic [NUM_CH*DATA_W-1:0] ch_rdata_i,
  input  logic [NUM_CH-1:0]        irq_i,
  input  logic [NUM_CH-1:0]        raw_i,
  input  logic                     bank_msk_i,
  input  logic                     bank_clr_i,
  input  logic                     bank_raw_i,
  output logic [DATA_W-1:0]        rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_CH; k++) rdata_o = rdata_o | ch_rdata_i[k*DATA_W +: DATA_W];
    if (bank_msk_i || bank_clr_i) rdata_o = rdata_o | DATA_W'(irq_i);
    if (bank_raw_i)               rdata_o = rdata_o | DATA_W'(raw_i);
  end
endmodule

// File: rtl/apb_timer_bank.sv
module apb_timer_bank
  import timer_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int unsigned OFF_W = $clog2(CH_SPAN);

  logic                     wr, rd;
  logic [NUM_CH-1:0]        ch_hit, raw_vec;
  logic [OFF_W-1:0]         ch_off;
  logic                     bank_msk, bank_clr, bank_raw, clr_all;
  logic [NUM_CH*DATA_W-1:0] ch_rdata;

  timer_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
    .psel_i, .penable_i, .pwrite_i, .paddr_i,
    .wr_o(wr), .rd_o(rd), .ch_hit_o(ch_hit), .ch_off_o(ch_off),
    .bank_msk_o(bank_msk), .bank_clr_o(bank_clr), .bank_raw_o(bank_raw)
  );

  assign clr_all = rd & bank_clr;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    timer_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_ch (
      .clk_i, .rst_ni,
      .sel_i(ch_hit[ch]), .wr_i(wr), .rd_i(rd), .off_i(ch_off),
      .wdata_i(pwdata_i), .bank_clr_i(clr_all),
      .rdata_o(ch_rdata[ch*DATA_W +: DATA_W]),
      .irq_o(irq_o[ch]), .raw_o(raw_vec[ch])
    );
  end

  timer_rdata_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_mux (
    .ch_rdata_i(ch_rdata), .irq_i(irq_o), .raw_i(raw_vec),
    .bank_msk_i(bank_msk), .bank_clr_i(bank_clr), .bank_raw_i(bank_raw),
    .rdata_o(prdata_o)
  );

  assign pready_o = 1'b1;

  p_mask_vec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bank_msk) |-> prdata_o == DATA_W'(irq_o));

  p_raw_vec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bank_raw) |-> prdata_o == DATA_W'(raw_vec));

  p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && ch_hit == '0 && !bank_msk && !bank_clr && !bank_raw) |-> prdata_o == '0);

  p_irq_needs_raw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[0]) |-> raw_vec[0]);
endmodule

// File: tb/tb_apb_timer_bank.sv
module tb_apb_timer_bank;
  localparam int NUM_CH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [7:0]  irq;

  int          checks = 0, errors = 0;
  int unsigned cyc = 0;
  bit          done = 0;

  logic [31:0] exp_q[$];
  logic [7:0]  addr_q[$];
  string       req_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  apb_timer_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready), .irq_o(irq)
  );

  function automatic logic [7:0] ra(input int ch, input int off);
    return 8'(ch * 20 + off);
  endfunction

  // kind 0: fixed; 1: reload period; 2: count from L then free-run wrap
  function automatic logic [31:0] exp_val(input int kind, input logic [31:0] v,
                                          input int unsigned c0, input int unsigned c);
    int unsigned n;
    n = c - c0;
    if (kind == 1) return v - 32'(n % (v + 1));
    if (kind == 2) return (32'(n) <= v) ? v - 32'(n) : 32'hFFFFFFFF - (32'(n) - v - 1);
    return v;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int unsigned c_edge);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1; c_edge = cyc + 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, input int kind, input logic [31:0] v,
                    input int unsigned c0, input string req);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    addr_q.push_back(a); exp_q.push_back(exp_val(kind, v, c0, cyc)); req_q.push_back(req);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard compare in the access phase
  always @(negedge clk) begin
    #1;
    if (psel && penable) begin
      chk(32'(pready), 32'd1, "R11 pready");
      if (!pwrite) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard: actual %h expected none", prdata);
        end else begin
          logic [31:0] e; logic [7:0] a; string r;
          e = exp_q.pop_front(); a = addr_q.pop_front(); r = req_q.pop_front();
          chk(prdata, e, $sformatf("%s @%h", r, a));
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned c0, cx;
    idle(3); rst_n = 1; idle(2);

    // R1 reset state
    chk(32'(irq), 32'd0, "R1 irq");
    rd(ra(0, 0), 0, 0, 0, "R1 load");
    rd(ra(0, 8), 0, 0, 0, "R1 ctrl");
    rd(ra(0, 4), 0, 0, 0, "R1 count");
    rd(8'hA8, 0, 0, 0, "R1 raw");

    // R2 map and control bits
    wr(ra(7, 0), 32'hDEADBEEF, cx);
    rd(ra(7, 0), 0, 32'hDEADBEEF, 0, "R2 ch7 load");
    wr(ra(5, 8), 32'hFFFFFFFE, cx);
    rd(ra(5, 8), 0, 32'h16, 0, "R2 ctrl bits");
    rd(ra(5, 4), 0, 0, 0, "R2 disabled count");

    // R3 R4 reload channel 1
    wr(ra(1, 0), 32'd5, cx);
    wr(ra(1, 8), 32'h3, c0);
    rd(ra(1, 4), 1, 5, c0, "R3 count");
    idle(10);
    rd(ra(1, 4), 1, 5, c0, "R4 reload");
    chk(32'(irq[1]), 1, "R4 irq");
    rd(ra(1, 16), 0, 1, 0, "R8 status");

    // R6 R7 stop then acknowledge
    wr(ra(1, 8), 32'h2, cx);
    rd(ra(1, 4), 0, 0, 0, "R6 count zero");
    chk(32'(irq[1]), 1, "R6 flag held");
    rd(ra(1, 12), 0, 1, 0, "R7 ack value");
    chk(32'(irq[1]), 0, "R7 cleared");
    rd(ra(1, 12), 0, 0, 0, "R7 second ack");

    // R8 R9 masked channel 3
    wr(ra(3, 0), 32'd3, cx);
    wr(ra(3, 8), 32'h7, cx);
    idle(8);
    chk(32'(irq[3]), 0, "R8 masked irq");
    rd(8'hA8, 0, 32'h08, 0, "R9 raw vec");
    rd(8'hA0, 0, 32'h00, 0, "R9 masked vec");
    rd(ra(3, 16), 0, 0, 0, "R8 masked status");
    wr(ra(3, 8), 32'h6, cx);
    wr(ra(3, 8), 32'h2, cx);
    chk(32'(irq[3]), 1, "R8 unmask");
    rd(8'hA0, 0, 32'h08, 0, "R9 masked vec after unmask");

    // R3 free-run start on channel 6
    wr(ra(6, 8), 32'h5, c0);
    rd(ra(6, 4), 2, 32'hFFFFFFFF, c0, "R3 free start");
    wr(ra(6, 8), 32'h0, cx);

    // R5 mode switch then wrap on channel 0
    wr(ra(0, 0), 32'd8, cx);
    wr(ra(0, 8), 32'h3, c0);
    wr(ra(0, 8), 32'h1, cx);
    rd(ra(0, 4), 2, 8, c0, "R5 no restart");
    idle(10);
    rd(ra(0, 4), 2, 8, c0, "R5 wrap");
    chk(32'(irq[0]), 1, "R5 flag");
    wr(ra(0, 8), 32'h0, cx);

    // R10 bank clear
    wr(ra(1, 8), 32'h3, cx);
    idle(10);
    wr(ra(1, 8), 32'h2, cx);
    rd(8'hA8, 0, 32'h0B, 0, "R9 raw before clear");
    rd(8'hA4, 0, 32'h0B, 0, "R10 clear read");
    rd(8'hA8, 0, 32'h00, 0, "R10 raw after clear");
    chk(32'(irq), 0, "R10 irq");

    // R11 ignored writes and unmapped reads
    wr(8'hA8, 32'hFF, cx);
    rd(8'hA8, 0, 0, 0, "R11 ro bank");
    wr(ra(0, 4), 32'h1234, cx);
    rd(ra(0, 4), 0, 0, 0, "R11 ro count");
    wr(8'hB0, 32'h55, cx);
    rd(8'hB0, 0, 0, 0, "R11 unmapped");
    rd(8'hFC, 0, 0, 0, "R11 unmapped high");
    rd(ra(7, 0), 0, 32'hDEADBEEF, 0, "R11 no alias");

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule